// File: doc/BRIEF.md
# Serial Transmit Data Intake Controller

This block collects transmit payload from an external controller over a one-wire serial link. It produces the bit clock for that link. It also decides on which phase of that clock each incoming bit is captured. Raising the transmit enable starts a packet and lowering it ends the packet. While the enable is high, a small state machine steps through its phases.

In internal-preamble mode, the block first counts out a programmable number of preamble bit periods and then a fixed-length header. It then raises a ready output, which tells the controller to start sending payload. In external-preamble mode, the preamble and header come from outside, so every bit after the start is payload and the ready output stays low.

Captured bits are packed into bytes least significant bit first. Each byte is handed to the spreading and modulation stage with a one-cycle valid strobe.

Top module: `tx_serial_ctrl`

## Requirements
- R1: Out of reset, `bit_clk`, `tx_rdy` and `byte_vld` are low.
- R2: A rising edge of `tx_en` starts a packet. `bit_clk` then begins low and toggles every 2^`rate_sel` clock cycles, so its first rising edge comes 2^`rate_sel` cycles after the clock edge that saw `tx_en` rise.
- R3: With `edge_sel` = 0, `ser_in` is captured at the falling edges of `bit_clk`. With `edge_sel` = 1, it is captured at the rising edges. Each capture counts as one bit period for every phase of the packet.
- R4: Payload bits are assembled least significant bit first: the first captured bit is `byte_out[0]`. `byte_vld` is high for exactly one cycle per completed byte, and `byte_out` changes only together with `byte_vld`.
- R5: With `int_pre` = 1, `tx_rdy` rises at the capture that completes `pre_len` preamble bit periods plus 48 header bit periods. No byte is delivered before `tx_rdy` rises.
- R6: With `int_pre` = 1 and `pre_len` = 0, the preamble phase is skipped and `tx_rdy` rises after the 48 header bit periods alone.
- R7: With `int_pre` = 0, every captured bit from the start of the packet is payload, and `tx_rdy` stays low throughout.
- R8: After `tx_en` falls, `tx_rdy` is low from the next clock edge and `bit_clk` is low from the edge after that. A partly assembled byte is discarded, so the next packet starts at bit 0 of a fresh byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tx_en | input | 1 | Packet envelope; rising edge starts, falling edge stops |
| int_pre | input | 1 | 1 = block runs preamble and header phases itself |
| edge_sel | input | 1 | 0 = capture on falling bit clock edge, 1 = on rising edge |
| rate_sel | input | RATE_W | Bit clock half period is 2^rate_sel core cycles |
| pre_len | input | PRE_W | Preamble length in bit periods (internal mode) |
| ser_in | input | 1 | Serial payload from the controller, LSB first |
| bit_clk | output | 1 | Bit clock driven to the controller |
| tx_rdy | output | 1 | Payload may be sent (internal mode only) |
| byte_out | output | BYTE_W | Last assembled byte |
| byte_vld | output | 1 | One-cycle strobe marking a new byte |

## Verification
The properties assume that `int_pre`, `edge_sel`, `rate_sel` and `pre_len` do not change while `tx_en` is high. They also assume the controller changes `ser_in` only on the bit clock phase opposite the capture phase. The bench changes the configuration only between packets, when `tx_en` has been low for several cycles. Its controller model updates `ser_in` just after each non-capturing `bit_clk` transition. With external preamble and rising-edge capture, it places the first bit before raising `tx_en`. This keeps `ser_in` stable for half a bit period on either side of each capture, so a capture on the wrong phase picks up the previous bit.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_HDR  = 2'd2,
    ST_DATA = 2'd3
  } txs_state_e;
endpackage

// File: rtl/txs_bitclk.sv
module txs_bitclk #(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              sample_rise,
  output logic              bit_clk,
  output logic              tick
);
  localparam int DIV_W = (1 << RATE_W) - 1;

  logic [DIV_W-1:0] cnt_q, cnt_d, lim;
  logic             bclk_q, bclk_d, toggle;

  assign lim    = DIV_W'((32'd1 << rate_sel) - 32'd1);
  assign toggle = run && (cnt_q == lim);
  // capture happens when the clock is about to move to the selected level
  assign tick   = toggle && (bclk_q != sample_rise);

  always_comb begin
    cnt_d  = cnt_q;
    bclk_d = bclk_q;
    if (!run) begin
      cnt_d  = '0;
      bclk_d = 1'b0;
    end else if (toggle) begin
      cnt_d  = '0;
      bclk_d = ~bclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  assign bit_clk = bclk_q;
endmodule

// File: rtl/txs_fsm.sv
module txs_fsm
  import txs_pkg::*;
#(
  parameter int PRE_W    = 6,
  parameter int HDR_BITS = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             int_pre,
  input  logic [PRE_W-1:0] pre_len,
  input  logic             tick,
  output txs_state_e       state,
  output logic             tx_rdy
);
  localparam int HW = $clog2(HDR_BITS);
  localparam int CW = (PRE_W > HW) ? PRE_W : HW;

  txs_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en_q, rdy_q, rdy_d, start;

  assign start = tx_en && !en_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (start) begin
          if (!int_pre)            st_d = ST_DATA;
          else if (pre_len == '0)  st_d = ST_HDR;
          else                     st_d = ST_PRE;
        end
      end
      ST_PRE: if (tick) begin
        if (cnt_q == CW'(pre_len) - CW'(1)) begin
          st_d  = ST_HDR;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_HDR: if (tick) begin
        if (cnt_q == CW'(HDR_BITS - 1)) begin
          st_d  = ST_DATA;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: ;
    endcase
    if (st_q != ST_IDLE && !tx_en) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end
    rdy_d = (st_d == ST_DATA) && int_pre;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      en_q  <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      en_q  <= tx_en;
      rdy_q <= rdy_d;
    end
  end

  assign state  = st_q;
  assign tx_rdy = rdy_q;
endmodule

// File: rtl/txs_deser.sv
module txs_deser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              take,
  input  logic              din,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_vld
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh_q, sh_d, out_q, out_d, shifted;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              vld_d, vld_q;

  // new bit enters at the top so the first bit ends at position 0
  assign shifted = {din, sh_q[BYTE_W-1:1]};

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    out_d = out_q;
    vld_d = 1'b0;
    if (!active) begin
      cnt_d = '0;
    end else if (take) begin
      sh_d = shifted;
      if (cnt_q == CNT_W'(BYTE_W - 1)) begin
        cnt_d = '0;
        out_d = shifted;
        vld_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      out_q <= out_d;
      vld_q <= vld_d;
    end
  end

  assign byte_out = out_q;
  assign byte_vld = vld_q;
endmodule

// File: rtl/tx_serial_ctrl.sv
module tx_serial_ctrl
  import txs_pkg::*;
#(
  parameter int PRE_W    = 6,
  parameter int HDR_BITS = 48,
  parameter int RATE_W   = 2,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              int_pre,
  input  logic              edge_sel,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [PRE_W-1:0]  pre_len,
  input  logic              ser_in,
  output logic              bit_clk,
  output logic              tx_rdy,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_vld
);
  txs_state_e state;
  logic       tick;
  logic       in_data;

  assign in_data = (state == ST_DATA);

  txs_bitclk #(.RATE_W(RATE_W)) u_clk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (state != ST_IDLE),
    .rate_sel    (rate_sel),
    .sample_rise (edge_sel),
    .bit_clk     (bit_clk),
    .tick        (tick)
  );

  txs_fsm #(.PRE_W(PRE_W), .HDR_BITS(HDR_BITS)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .int_pre (int_pre),
    .pre_len (pre_len),
    .tick    (tick),
    .state   (state),
    .tx_rdy  (tx_rdy)
  );

  txs_deser #(.BYTE_W(BYTE_W)) u_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (in_data),
    .take     (in_data && tick),
    .din      (ser_in),
    .byte_out (byte_out),
    .byte_vld (byte_vld)
  );
endmodule

// File: rtl/tx_serial_ctrl_chk.sv
module tx_serial_ctrl_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              int_pre,
  input logic              bit_clk,
  input logic              tx_rdy,
  input logic [BYTE_W-1:0] byte_out,
  input logic              byte_vld
);
  // R7
  rdy_internal_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rdy |-> int_pre);

  // R5
  rdy_rise_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_rdy) |-> $past(tx_en));

  // R5
  no_byte_before_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (!int_pre || tx_rdy));

  // R8
  rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_rdy);

  // R8
  bitclk_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !$past(tx_en)) |=> !bit_clk);

  // R4
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);

  // R4
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte_out) |-> byte_vld);
endmodule

bind tx_serial_ctrl tx_serial_ctrl_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_en    (tx_en),
  .int_pre  (int_pre),
  .bit_clk  (bit_clk),
  .tx_rdy   (tx_rdy),
  .byte_out (byte_out),
  .byte_vld (byte_vld)
);

// File: tb/tb_tx_serial_ctrl.sv
module tb_tx_serial_ctrl;
  localparam int HDR = 48;

  logic       clk, rst_n, tx_en, int_pre, edge_sel, ser_in;
  logic [1:0] rate_sel;
  logic [5:0] pre_len;
  logic       bit_clk, tx_rdy, byte_vld;
  logic [7:0] byte_out;

  int checks = 0;
  int errors = 0;

  logic [7:0] tx_mem [0:7];
  logic [7:0] rx_mem [0:15];
  int         rx_n;

  tx_serial_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .int_pre(int_pre),
    .edge_sel(edge_sel), .rate_sel(rate_sel), .pre_len(pre_len),
    .ser_in(ser_in), .bit_clk(bit_clk), .tx_rdy(tx_rdy),
    .byte_out(byte_out), .byte_vld(byte_vld)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (byte_vld) begin
      if (rx_n < 16) rx_mem[rx_n] = byte_out;
      rx_n = rx_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_rdy_cyc(int h, int pre, int edg);
    return h * (2 * (pre + HDR) - edg) + 1;
  endfunction

  function automatic logic bit_at(int idx);
    return tx_mem[idx / 8][idx % 8];
  endfunction

  task automatic run_pkt(input bit ip, input bit edg, input int rs,
                         input int pre, input int nbytes, input int extra);
    int  nbits, idx, ds, cyc, first_rise, rdy_cyc, rx_at_rdy;
    bit  rdy_seen, rdy_old, ext_rdy, prev;
    int  h;
    @(negedge clk);
    int_pre  = ip;
    edge_sel = edg;
    rate_sel = 2'(rs);
    pre_len  = 6'(pre);
    ser_in   = 1'b0;
    rx_n     = 0;
    h        = 1 << rs;
    for (int i = 0; i < nbytes; i++) tx_mem[i] = 8'($urandom);
    if (extra > 0) tx_mem[nbytes] = 8'($urandom);
    nbits = nbytes * 8 + extra;
    idx = 0; ds = 0; cyc = 0; first_rise = -1; rdy_cyc = -1; rx_at_rdy = 0;
    ext_rdy = 0; prev = 1'b0;
    rdy_seen = !ip;
    if (!ip && edg) begin
      ser_in = bit_at(0);
      idx = 1;
    end
    @(negedge clk);
    tx_en = 1'b1;
    while (ds < nbits && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      rdy_old = rdy_seen;
      if (bit_clk != prev) begin
        if (bit_clk && first_rise < 0) first_rise = cyc;
        if (rdy_old && bit_clk == edg) ds++;
        if (rdy_old && bit_clk != edg && idx < nbits) begin
          ser_in = bit_at(idx);
          idx++;
        end
      end
      prev = bit_clk;
      if (!ip && tx_rdy) ext_rdy = 1;
      if (ip && !rdy_seen && tx_rdy) begin
        rdy_seen  = 1;
        rdy_cyc   = cyc;
        rx_at_rdy = rx_n;
      end
    end
    // R2 first bit clock rise
    chk(first_rise == h + 1, "R2 first bit_clk rise", first_rise, h + 1);
    if (ip) begin
      // R5 / R6 ready timing
      chk(rdy_cyc == exp_rdy_cyc(h, pre, edg),
          (pre == 0) ? "R6 ready timing, no preamble" : "R5 ready timing",
          rdy_cyc, exp_rdy_cyc(h, pre, edg));
      chk(rx_at_rdy == 0, "R5 no byte before ready", rx_at_rdy, 0);
    end else begin
      chk(!ext_rdy, "R7 ready low in external mode", ext_rdy, 0);
    end
    tx_en = 1'b0;
    @(negedge clk);
    chk(tx_rdy == 1'b0, "R8 ready drops after enable falls", tx_rdy, 0);
    @(negedge clk);
    chk(bit_clk == 1'b0, "R8 bit clock parked", bit_clk, 0);
    repeat (4) @(negedge clk);
    chk(rx_n == nbytes, "R4 byte count", rx_n, nbytes);
    for (int i = 0; i < nbytes && i < rx_n && i < 16; i++)
      chk(rx_mem[i] == tx_mem[i], edg ? "R4 R3 byte, rising capture" :
          "R4 R3 byte, falling capture", rx_mem[i], tx_mem[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; tx_en = 1'b0; int_pre = 1'b0; edge_sel = 1'b0;
    rate_sel = 2'd0; pre_len = 6'd0; ser_in = 1'b0; rx_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bit_clk == 1'b0, "R1 bit_clk in reset", bit_clk, 0);
    chk(tx_rdy == 1'b0, "R1 tx_rdy in reset", tx_rdy, 0);
    chk(byte_vld == 1'b0, "R1 byte_vld in reset", byte_vld, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(bit_clk == 1'b0 && tx_rdy == 1'b0, "R1 idle after reset", bit_clk, 0);

    // directed corners
    run_pkt(1'b0, 1'b1, 0, 0, 2, 0);   // R7 external, rising capture, fastest
    run_pkt(1'b0, 1'b0, 3, 0, 2, 0);   // R7 external, falling capture, slowest
    run_pkt(1'b1, 1'b0, 1, 5, 2, 0);   // R5 internal with preamble
    run_pkt(1'b1, 1'b1, 2, 0, 1, 0);   // R6 preamble skipped
    run_pkt(1'b0, 1'b1, 1, 0, 1, 3);   // R8 abort mid-byte
    run_pkt(1'b0, 1'b0, 1, 0, 2, 0);   // R8 next packet starts fresh
    run_pkt(1'b1, 1'b0, 0, 1, 1, 5);   // R8 abort in internal mode

    // random packets
    for (int k = 0; k < 14; k++)
      run_pkt(1'($urandom), 1'($urandom), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 7)), int'($urandom_range(1, 4)),
              int'($urandom_range(0, 1)) * int'($urandom_range(1, 7)));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule